// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver with End-of-Interrupt Control

This block arbitrates eight interrupt request lines and tracks which levels are being serviced. Each level has a rank under a rotating priority scheme. A 3-bit pointer names the lowest-ranked level, and the level just above it, (pointer+1) mod 8, ranks highest. A request is forwarded on `irq_out` with its level on `irq_idx` only when it outranks every level now in service. A one-cycle acknowledge then marks the forwarded level as in service.

Software steers the block with one 8-bit command byte on `wr_data` while `wr_en` is high. Bits 4:3 pick the target: 00 is this block's command register, 01 is a neighbouring command register, and 1x is the initialization register. Writes to the neighbour or to initialization only raise `sibling_wr` or `init_wr` in the same cycle. For this block's own register, bits 7:5 hold an operation code and bits 2:0 name a level. The operation can end a service period, move the priority pointer, or switch automatic rotation on or off.

Automatic rotation is a two-state machine. In `MODE_FIXED`, ending a service period leaves the pointer alone. In `MODE_AUTO`, the level whose in-service bit an end-of-interrupt clears becomes the new lowest rank. The transition `MODE_FIXED`→`MODE_AUTO` happens on operation codes 100 and 101. The transition `MODE_AUTO`→`MODE_FIXED` happens on code 000. Every other write and every cycle without a write keeps the state.

Top module: `irq_eoi_ctrl`

## Requirements
- R1: After reset, `isr_q` is 0, `low_prio` is 7 (so level 0 ranks highest), the mode is fixed, and `irq_out` is 0.
- R2: The rank of level n is (n − low_prio − 1) mod 8, where rank 0 is highest. Among the set bits of `irq_req`, the level with the smallest rank wins.
- R3: `irq_out` is 1 only when the winning request ranks strictly above every set bit of `isr_q`. `irq_out` and `irq_idx` follow `irq_req` and `isr_q` with no register delay. `irq_idx` shows the winner while `irq_out` is 1 and is 0 otherwise.
- R4: An `int_ack` cycle with `irq_out` high sets `isr_q[irq_idx]` at the next edge. An `int_ack` cycle with `irq_out` low changes nothing.
- R5: Operation code 001 (a non-specific end-of-interrupt) clears the set `isr_q` bit with the smallest rank. If `isr_q` is 0, it has no effect.
- R6: Operation code 011 clears `isr_q[wr_data[2:0]]`. If that bit is already clear, nothing changes.
- R7: Operation code 010 changes nothing. When bit 6 is 0, bits 2:0 have no effect on the result.
- R8: Code 100 enters `MODE_AUTO` and code 000 returns to `MODE_FIXED`. In `MODE_AUTO`, an end-of-interrupt that clears a set bit n makes `low_prio` equal n. In `MODE_FIXED`, `low_prio` stays unchanged.
- R9: Code 101 enters `MODE_AUTO` and performs a non-specific end-of-interrupt that also rotates. If `isr_q` is 0, only the mode changes.
- R10: Code 110 loads `low_prio` from bits 2:0. Code 111 loads `low_prio` from bits 2:0 and also clears `isr_q` at that level.
- R11: When bits 4:3 are not 00, `sibling_wr` (for 01) or `init_wr` (for 1x) is high in the same cycle as `wr_en`, and the block's state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command byte write strobe |
| wr_data | input | 8 | Command byte |
| irq_req | input | 8 | Interrupt request lines, one per level |
| int_ack | input | 1 | One-cycle acknowledge of the forwarded request |
| irq_out | output | 1 | Forwarded interrupt |
| irq_idx | output | 3 | Level of the forwarded interrupt |
| isr_q | output | 8 | In-service vector |
| low_prio | output | 3 | Level that currently ranks lowest |
| sibling_wr | output | 1 | Write aimed at the neighbouring command register |
| init_wr | output | 1 | Write aimed at the initialization register |

## Verification
The bench targets the ways priority wraps around the pointer and how end-of-interrupt interacts with rotation. A resolver that ignores the pointer would pick level 0 over level 5 after a rotation to 4. A non-specific end-of-interrupt that searched in fixed order would clear the wrong level once the levels have rotated. An automatic mode that also rotated on a specific end-of-interrupt to an idle level, or on 101 with nothing in service, would move the pointer when it should not. The bench also checks that an acknowledge without a forwarded interrupt is ignored, that the level field has no effect when bit 6 is 0, and that writes with a non-zero select field only raise their strobe. A random mix of commands and acknowledges is then compared against a reference model of the pointer, the mode and the in-service bits.

// File: rtl/irq_eoi_pkg.sv
package irq_eoi_pkg;

    localparam int CMD_W = 8;
    localparam int LVL_W = 3;
    localparam int N_LVL = 1 << LVL_W;

    // operation code held in command bits 7:5 (rotate, level-select, end)
    typedef enum logic [2:0] {
        OP_AUTO_OFF    = 3'b000,
        OP_NS_EOI      = 3'b001,
        OP_NOP         = 3'b010,
        OP_SP_EOI      = 3'b011,
        OP_AUTO_ON     = 3'b100,
        OP_AUTO_NS_EOI = 3'b101,
        OP_SET_LOW     = 3'b110,
        OP_SET_LOW_EOI = 3'b111
    } op_e;

    typedef enum logic {
        MODE_FIXED = 1'b0,
        MODE_AUTO  = 1'b1
    } rot_mode_e;

    typedef struct packed {
        logic             own_wr;
        logic             sib_wr;
        logic             init_wr;
        op_e              op;
        logic [LVL_W-1:0] lvl;
    } cmd_t;

endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
    import irq_eoi_pkg::*;
(
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wr_data,
    output cmd_t             cmd
);
    logic [1:0] sel;
    assign sel = wr_data[4:3];

    always_comb begin
        cmd         = '0;
        cmd.op      = op_e'(wr_data[7:5]);
        cmd.lvl     = wr_data[LVL_W-1:0];
        if (wr_en) begin
            unique case (sel)
                2'b00:   cmd.own_wr  = 1'b1;
                2'b01:   cmd.sib_wr  = 1'b1;
                default: cmd.init_wr = 1'b1;
            endcase
        end
    end

    // R11: a write reaches exactly one register
    always_comb begin
        a_r11_one_target: assert ($onehot0({cmd.own_wr, cmd.sib_wr, cmd.init_wr}));
    end

endmodule

// File: rtl/irq_rot_pick.sv
module irq_rot_pick
    import irq_eoi_pkg::*;
#(
    parameter int N = N_LVL,
    parameter int W = LVL_W
) (
    input  logic [N-1:0] vec,
    input  logic [W-1:0] low,
    output logic         hit,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rank
);
    localparam int SW = W + 1;

    logic [N-1:0] rot_vec;

    // rot_vec[k] is the level holding rank k
    for (genvar k = 0; k < N; k++) begin : g_rot
        logic [SW-1:0] s_k;
        logic [W-1:0]  p_k;
        assign s_k = {1'b0, low} + SW'(k + 1);
        assign p_k = (s_k >= SW'(N)) ? W'(s_k - SW'(N)) : s_k[W-1:0];
        assign rot_vec[k] = vec[p_k];
    end

    always_comb begin
        hit  = 1'b0;
        rank = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (rot_vec[k]) begin
                hit  = 1'b1;
                rank = W'(k);
            end
        end
    end

    logic [SW-1:0] s_w;
    assign s_w = {1'b0, low} + {1'b0, rank} + SW'(1);
    assign lvl = (s_w >= SW'(N)) ? W'(s_w - SW'(N)) : s_w[W-1:0];

endmodule

// File: rtl/irq_isr_bank.sv
module irq_isr_bank
    import irq_eoi_pkg::*;
#(
    parameter int N = N_LVL
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] isr_q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) isr_q[i] <= 1'b0;
            else        isr_q[i] <= (isr_q[i] & ~clr_vec[i]) | set_vec[i];
        end
    end

    // R4: an acknowledge marks one level only
    a_r4_single_set: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_vec));
    // R5: an end-of-interrupt clears one level only
    a_r5_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_vec));
    // R4: a set bit lands at the next edge
    a_r4_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((isr_q & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/irq_eoi_ctrl.sv
module irq_eoi_ctrl
    import irq_eoi_pkg::*;
#(
    parameter int N = N_LVL,
    parameter int W = LVL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wr_data,
    input  logic [N-1:0]     irq_req,
    input  logic             int_ack,
    output logic             irq_out,
    output logic [W-1:0]     irq_idx,
    output logic [N-1:0]     isr_q,
    output logic [W-1:0]     low_prio,
    output logic             sibling_wr,
    output logic             init_wr
);
    localparam logic [W-1:0] LOW_RST = W'(N - 1);

    cmd_t          cmd;
    rot_mode_e     mode_q, mode_d;
    logic [W-1:0]  low_q, low_d;
    logic [N-1:0]  set_vec, clr_vec;
    logic          req_hit, isr_hit;
    logic [W-1:0]  req_lvl, req_rank, isr_lvl, isr_rank;

    irq_cmd_decode u_dec (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    irq_rot_pick #(.N(N), .W(W)) u_pick_req (
        .vec  (irq_req),
        .low  (low_q),
        .hit  (req_hit),
        .lvl  (req_lvl),
        .rank (req_rank)
    );

    irq_rot_pick #(.N(N), .W(W)) u_pick_isr (
        .vec  (isr_q),
        .low  (low_q),
        .hit  (isr_hit),
        .lvl  (isr_lvl),
        .rank (isr_rank)
    );

    irq_isr_bank #(.N(N)) u_isr (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .isr_q   (isr_q)
    );

    // state register: rotation mode and priority pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_FIXED;
            low_q  <= LOW_RST;
        end else begin
            mode_q <= mode_d;
            low_q  <= low_d;
        end
    end

    // next state and end-of-interrupt actions
    always_comb begin
        mode_d  = mode_q;
        low_d   = low_q;
        clr_vec = '0;
        if (cmd.own_wr) begin
            unique case (cmd.op)
                OP_AUTO_OFF: mode_d = MODE_FIXED;
                OP_NS_EOI: begin
                    if (isr_hit) begin
                        clr_vec[isr_lvl] = 1'b1;
                        if (mode_q == MODE_AUTO) low_d = isr_lvl;
                    end
                end
                OP_NOP: ;
                OP_SP_EOI: begin
                    clr_vec[cmd.lvl] = 1'b1;
                    if (mode_q == MODE_AUTO && isr_q[cmd.lvl]) low_d = cmd.lvl;
                end
                OP_AUTO_ON: mode_d = MODE_AUTO;
                OP_AUTO_NS_EOI: begin
                    mode_d = MODE_AUTO;
                    if (isr_hit) begin
                        clr_vec[isr_lvl] = 1'b1;
                        low_d            = isr_lvl;
                    end
                end
                OP_SET_LOW: low_d = cmd.lvl;
                OP_SET_LOW_EOI: begin
                    low_d            = cmd.lvl;
                    clr_vec[cmd.lvl] = 1'b1;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        irq_out    = req_hit && (!isr_hit || (req_rank < isr_rank));
        irq_idx    = irq_out ? req_lvl : '0;
        set_vec    = '0;
        if (int_ack && irq_out) set_vec[req_lvl] = 1'b1;
        low_prio   = low_q;
        sibling_wr = cmd.sib_wr;
        init_wr    = cmd.init_wr;
    end

    a_r2_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> irq_req[irq_idx]);
    a_r3_not_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> !isr_q[irq_idx]);
    a_r4_ack_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && irq_out && !wr_en) |=> isr_q[$past(irq_idx)]);
    a_r8_auto_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7:3] == 5'b00000) |=> (mode_q == MODE_FIXED));
    a_r9_auto_on: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7:3] == 5'b10100) |=> (mode_q == MODE_AUTO));
    a_r10_set_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7:6] == 2'b11 && wr_data[4:3] == 2'b00)
        |=> (low_prio == $past(wr_data[W-1:0])));
    a_r11_foreign_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[4:3] != 2'b00) |=> $stable(low_prio));

endmodule

// File: tb/irq_eoi_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_eoi_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] irq_req = '0;
    logic       int_ack = 1'b0;
    logic       irq_out;
    logic [2:0] irq_idx;
    logic [7:0] isr_q;
    logic [2:0] low_prio;
    logic       sibling_wr, init_wr;

    always #4 clk = ~clk;

    irq_eoi_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .irq_req(irq_req), .int_ack(int_ack), .irq_out(irq_out),
        .irq_idx(irq_idx), .isr_q(isr_q), .low_prio(low_prio),
        .sibling_wr(sibling_wr), .init_wr(init_wr)
    );

    typedef struct {
        logic       irq;
        logic [2:0] idx;
        logic [7:0] isr;
        logic [2:0] low;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    logic [7:0] m_isr;
    logic [2:0] m_low;
    bit         m_auto;

    function automatic void pick(input logic [7:0] v, input logic [2:0] lo,
                                 output bit hit, output logic [2:0] lvl, output int rank);
        hit = 0; lvl = '0; rank = 8;
        for (int k = 7; k >= 0; k--) begin
            logic [2:0] p;
            p = 3'(int'(lo) + 1 + k);
            if (v[p]) begin hit = 1; lvl = p; rank = k; end
        end
    endfunction

    function automatic void model_irq(output bit irq, output logic [2:0] idx);
        bit hr, hi; logic [2:0] lr, li; int rr, ri;
        pick(irq_req, m_low, hr, lr, rr);
        pick(m_isr, m_low, hi, li, ri);
        irq = hr && (!hi || rr < ri);
        idx = irq ? lr : 3'd0;
    endfunction

    function automatic void model_cmd(input logic [7:0] d);
        bit h; logic [2:0] il; int ir; logic [2:0] lv;
        if (d[4:3] != 2'b00) return;
        lv = d[2:0];
        pick(m_isr, m_low, h, il, ir);
        case (d[7:5])
            3'd0: m_auto = 0;
            3'd1: if (h) begin m_isr[il] = 1'b0; if (m_auto) m_low = il; end
            3'd2: ;
            3'd3: begin if (m_auto && m_isr[lv]) m_low = lv; m_isr[lv] = 1'b0; end
            3'd4: m_auto = 1;
            3'd5: begin m_auto = 1; if (h) begin m_isr[il] = 1'b0; m_low = il; end end
            3'd6: m_low = lv;
            default: begin m_low = lv; m_isr[lv] = 1'b0; end
        endcase
    endfunction

    task automatic push(input string tag);
        exp_t e; bit irq; logic [2:0] idx;
        model_irq(irq, idx);
        e.irq = irq; e.idx = idx; e.isr = m_isr; e.low = m_low; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: compare on the falling edge, away from the active edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (irq_out !== e.irq || irq_idx !== e.idx || isr_q !== e.isr || low_prio !== e.low) begin
                n_fail++;
                $display("FAIL %s: got irq=%0b idx=%0d isr=%02h low=%0d exp irq=%0b idx=%0d isr=%02h low=%0d",
                         e.tag, irq_out, irq_idx, isr_q, low_prio, e.irq, e.idx, e.isr, e.low);
            end
        end
    end

    task automatic do_write(input logic [7:0] d, input string tag);
        wr_data = d; wr_en = 1'b1;
        #1;
        n_chk++;
        if (sibling_wr !== (d[4:3] == 2'b01) || init_wr !== d[4]) begin
            n_fail++;
            $display("FAIL R11 strobes (%s): got sib=%0b init=%0b exp sib=%0b init=%0b",
                     tag, sibling_wr, init_wr, d[4:3] == 2'b01, d[4]);
        end
        @(posedge clk); #2;
        wr_en = 1'b0;
        model_cmd(d);
        push(tag);
        @(negedge clk); #1;
    endtask

    task automatic do_ack(input string tag);
        bit irq; logic [2:0] idx;
        model_irq(irq, idx);
        int_ack = 1'b1;
        @(posedge clk); #2;
        int_ack = 1'b0;
        if (irq) m_isr[idx] = 1'b1;
        push(tag);
        @(negedge clk); #1;
    endtask

    task automatic set_req(input logic [7:0] v, input string tag);
        irq_req = v;
        push(tag);
        @(negedge clk); #1;
    endtask

    initial begin
        #1500000;
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        m_isr = '0; m_low = 3'd7; m_auto = 0;
        push("R1 reset state");
        @(negedge clk); #1;

        set_req(8'h05, "R2 fixed order picks level 0");
        set_req(8'h84, "R2 level 2 beats level 7");
        do_ack("R4 ack marks level 2");
        set_req(8'h88, "R3 lower ranks masked by level 2");
        set_req(8'h03, "R3 higher rank passes");
        do_ack("R4 nested ack level 0");
        set_req(8'h00, "R3 no request no irq");
        do_ack("R4 ack without irq ignored");
        do_write(8'h45, "R7 no-op code leaves state");
        do_write(8'h25, "R5 nonspecific clears level 0, R7 level field ignored");
        do_write(8'h20, "R5 nonspecific clears level 2");
        do_write(8'h20, "R5 empty isr no effect");
        do_write(8'hC4, "R10 rotate lowest to 4");
        set_req(8'h21, "R2 after rotation level 5 beats 0");
        do_ack("R4 ack level 5");
        set_req(8'h01, "R3 rotated masking of level 0");
        do_write(8'h63, "R6 specific EOI on idle level");
        do_write(8'h65, "R6 specific EOI clears level 5");
        do_write(8'h80, "R8 enter auto rotation");
        do_ack("R4 ack level 0 in auto");
        do_write(8'h20, "R8 auto EOI makes level 0 lowest");
        do_write(8'h00, "R8 leave auto rotation");
        set_req(8'h02, "R2 level 1 ranks highest");
        do_ack("R4 ack level 1");
        do_write(8'h20, "R8 fixed EOI keeps pointer");
        do_write(8'hA0, "R9 auto plus EOI with empty isr");
        do_ack("R4 ack level 1 again");
        do_write(8'hA3, "R9 auto EOI rotates, R7 level ignored");
        do_ack("R4 ack before rotate-clear");
        do_write(8'hE1, "R10 rotate and clear level 1");
        set_req(8'hFF, "R2 full request vector");
        do_ack("R4 ack under full vector");
        do_write(8'h08, "R11 sibling select holds state");
        do_write(8'h10, "R11 init select holds state");
        do_write(8'hF9, "R11 init select ignores opcode");
        do_write(8'h6F, "R11 sibling select ignores specific EOI");

        for (int i = 0; i < 600; i++) begin
            int a;
            a = $urandom_range(0, 7);
            if (a < 2) begin
                set_req(8'($urandom()), "R2 R3 random request");
            end else if (a < 4) begin
                do_ack("R4 random ack");
            end else begin
                logic [7:0] d;
                d = 8'($urandom());
                if ($urandom_range(0, 3) != 0) d[4:3] = 2'b00;
                do_write(d, "R5 R6 R8 R9 R10 random command");
            end
        end

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule